// File: doc/BRIEF.md
# Vector Instruction Legality Checker

This block sits in the decode stage of a vector unit. It decides whether a decoded vector instruction has to raise an illegal-instruction exception. The decision is based on the vector type state, the element start index, the destination register, the mask enable and the operand widths and group multipliers. A class selector picks the set of rules that applies. A second result says whether a source register group may overlap the destination group without breaking the placement rules. That result depends on which of the two groups is wider.

Both results are computed combinationally and then captured in one pipeline register, so they are available to the next decode sub-stage. Opcode decode and raising the trap happen outside this block.

Top module: `vec_legal_chk`

## Requirements
- R1: When `vtype_ill` is 1, `illegal_q` is 1 for every class code.
- R2: A width/multiplier pair is acceptable only if the width is from 8 to ELEN inclusive and the log2 multiplier is from -3 to +3. The data pair is checked for class 2 (variable-width), class 5 (load) and class 6 (store). The index pair is checked for class 7 (indexed load) and class 8 (indexed store).
- R3: In classes 0 (normal), 2, 5 and 7, an instruction with `vm`=0 and `vd_idx`=0 is illegal. With `vm`=1, destination 0 is accepted.
- R4: In class 1 (masked destination), `vd_idx`=0 is illegal whatever the value of `vm`.
- R5: Class 3 (reduction) and class 4 (widening reduction) are illegal when `vstart` is not 0.
- R6: Class 4 is also illegal when `data_eew` is outside 8..ELEN. For this class `data_pow` has no effect.
- R7: For classes 5 to 8, the segment limit uses `data_pow`. With a non-negative power, `seg_nf` times 2^pow must not exceed 8. With a negative power, the integer quotient `seg_nf` / 2^(-pow) must not exceed 8.
- R8: Classes 6 and 8 ignore `vm` and `vd_idx`.
- R9: Class codes 9 to 15 are always illegal.
- R10: A group covers 2^pow registers when pow > 0 and one register otherwise. When the source power is below the destination power, `ovl_ok_q` is 1 only in three cases: the source ends at or below the destination start, the source starts at or beyond the destination end, or both groups end on the same register and the source power is at least 0.
- R11: When the source power is above the destination power, `ovl_ok_q` is 1 only if the destination start is at or below the source start, or at or beyond the source end. Equal powers always give 1. Group ends are computed without wrapping past register 31.
- R12: Both outputs are 0 while `rst_n` is low. Otherwise each output shows the result for the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_sel | input | 4 | Instruction class code (0..8) |
| vtype_ill | input | 1 | Vector type marked illegal |
| vstart | input | VSTART_W | Start element index |
| vd_idx | input | REG_W | Destination register index (also the overlap destination) |
| vm | input | 1 | 1 = unmasked, 0 = masked by v0 |
| seg_nf | input | NF_W | Segment field count |
| data_eew | input | EEW_W | Data element width in bits |
| data_pow | input | POW_W | Signed log2 data group multiplier |
| idx_eew | input | EEW_W | Index element width in bits |
| idx_pow | input | POW_W | Signed log2 index group multiplier |
| ovl_src_idx | input | REG_W | Overlap source group base register |
| ovl_src_pow | input | POW_W | Signed log2 source group multiplier |
| ovl_dst_pow | input | POW_W | Signed log2 destination group multiplier |
| illegal_q | output | 1 | Registered illegal-instruction verdict |
| ovl_ok_q | output | 1 | Registered overlap-allowed verdict |

## Verification
Both verdicts are due exactly one rising edge after the inputs that produce them. The bench applies each input set just after a falling edge. It compares both outputs at the next falling edge against a model computed from that same input set. Every clock therefore carries a check, and no sample is taken close to the capturing edge. During reset the outputs are compared against 0 instead.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_NORMAL   = 4'd0,
    CLS_MASKDST  = 4'd1,
    CLS_VARWIDTH = 4'd2,
    CLS_RED      = 4'd3,
    CLS_WRED     = 4'd4,
    CLS_LOAD     = 4'd5,
    CLS_STORE    = 4'd6,
    CLS_IDXLOAD  = 4'd7,
    CLS_IDXSTORE = 4'd8
  } vlc_cls_e;
endpackage

// File: rtl/vlc_pair_chk.sv
module vlc_pair_chk #(
  parameter int EEW_W = 8,
  parameter int POW_W = 4,
  parameter int ELEN  = 64
) (
  input  logic [EEW_W-1:0]        eew,
  input  logic signed [POW_W-1:0] pow,
  output logic                    width_ok,
  output logic                    pair_ok
);
  localparam logic [EEW_W-1:0]        EEW_MIN = EEW_W'(8);
  localparam logic [EEW_W-1:0]        EEW_MAX = EEW_W'(ELEN);
  localparam logic signed [POW_W-1:0] POW_MIN = -3;
  localparam logic signed [POW_W-1:0] POW_MAX = 3;

  always_comb begin
    width_ok = (eew >= EEW_MIN) && (eew <= EEW_MAX);
    pair_ok  = width_ok && (pow >= POW_MIN) && (pow <= POW_MAX);
  end
endmodule

// File: rtl/vlc_seg_chk.sv
module vlc_seg_chk #(
  parameter int NF_W      = 4,
  parameter int POW_W     = 4,
  parameter int GRP_LIMIT = 8
) (
  input  logic [NF_W-1:0]         nf,
  input  logic signed [POW_W-1:0] pow,
  output logic                    seg_ok
);
  localparam int PW = NF_W + (1 << (POW_W - 1)) + 1;

  logic [PW-1:0]    nf_ext;
  logic [POW_W-1:0] mag;
  logic [PW-1:0]    scaled;

  always_comb begin
    nf_ext = PW'(nf);
    mag    = pow[POW_W-1] ? POW_W'(-pow) : POW_W'(pow);
    scaled = pow[POW_W-1] ? (nf_ext >> mag) : (nf_ext << mag);
    seg_ok = scaled <= PW'(GRP_LIMIT);
  end
endmodule

// File: rtl/vlc_overlap.sv
module vlc_overlap #(
  parameter int REG_W = 5,
  parameter int POW_W = 4
) (
  input  logic [REG_W-1:0]        src_idx,
  input  logic [REG_W-1:0]        dst_idx,
  input  logic signed [POW_W-1:0] src_pow,
  input  logic signed [POW_W-1:0] dst_pow,
  output logic                    ok
);
  localparam int SUM_W = REG_W + (1 << (POW_W - 1)) + 1;

  logic [SUM_W-1:0] s_base, d_base, s_len, d_len, s_end, d_end;

  function automatic logic [SUM_W-1:0] grp_len(input logic signed [POW_W-1:0] p);
    logic [SUM_W-1:0] one;
    one = SUM_W'(1);
    if (p > 0) grp_len = one << p[POW_W-2:0];
    else       grp_len = one;
  endfunction

  always_comb begin
    s_base = SUM_W'(src_idx);
    d_base = SUM_W'(dst_idx);
    s_len  = grp_len(src_pow);
    d_len  = grp_len(dst_pow);
    s_end  = s_base + s_len;
    d_end  = d_base + d_len;
    if (src_pow < dst_pow) begin
      ok = (s_end <= d_base) || (s_base >= d_end) ||
           ((s_end == d_end) && !src_pow[POW_W-1]);
    end else if (src_pow > dst_pow) begin
      ok = (d_base <= s_base) || (d_base >= s_end);
    end else begin
      ok = 1'b1;
    end
  end
endmodule

// File: rtl/vec_legal_chk.sv
module vec_legal_chk
  import vlc_pkg::*;
#(
  parameter int ELEN      = 64,
  parameter int VSTART_W  = 16,
  parameter int REG_W     = 5,
  parameter int NF_W      = 4,
  parameter int EEW_W     = 8,
  parameter int POW_W     = 4,
  parameter int GRP_LIMIT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              cls_sel,
  input  logic                    vtype_ill,
  input  logic [VSTART_W-1:0]     vstart,
  input  logic [REG_W-1:0]        vd_idx,
  input  logic                    vm,
  input  logic [NF_W-1:0]         seg_nf,
  input  logic [EEW_W-1:0]        data_eew,
  input  logic signed [POW_W-1:0] data_pow,
  input  logic [EEW_W-1:0]        idx_eew,
  input  logic signed [POW_W-1:0] idx_pow,
  input  logic [REG_W-1:0]        ovl_src_idx,
  input  logic signed [POW_W-1:0] ovl_src_pow,
  input  logic signed [POW_W-1:0] ovl_dst_pow,
  output logic                    illegal_q,
  output logic                    ovl_ok_q
);
  logic data_w_ok, data_pair_ok, idx_w_ok, idx_pair_ok, seg_ok, ovl_ok_d;
  logic mask_bad, vstart_bad, illegal_d;
  vlc_cls_e cls;

  vlc_pair_chk #(.EEW_W(EEW_W), .POW_W(POW_W), .ELEN(ELEN)) u_data_pair (
    .eew(data_eew), .pow(data_pow), .width_ok(data_w_ok), .pair_ok(data_pair_ok));

  vlc_pair_chk #(.EEW_W(EEW_W), .POW_W(POW_W), .ELEN(ELEN)) u_idx_pair (
    .eew(idx_eew), .pow(idx_pow), .width_ok(idx_w_ok), .pair_ok(idx_pair_ok));

  vlc_seg_chk #(.NF_W(NF_W), .POW_W(POW_W), .GRP_LIMIT(GRP_LIMIT)) u_seg (
    .nf(seg_nf), .pow(data_pow), .seg_ok(seg_ok));

  vlc_overlap #(.REG_W(REG_W), .POW_W(POW_W)) u_ovl (
    .src_idx(ovl_src_idx), .dst_idx(vd_idx),
    .src_pow(ovl_src_pow), .dst_pow(ovl_dst_pow), .ok(ovl_ok_d));

  always_comb begin
    cls        = vlc_cls_e'(cls_sel);
    mask_bad   = !vm && (vd_idx == '0);
    vstart_bad = vstart != '0;
    unique case (cls)
      CLS_NORMAL:   illegal_d = mask_bad;
      CLS_MASKDST:  illegal_d = vd_idx == '0;
      CLS_VARWIDTH: illegal_d = mask_bad || !data_pair_ok;
      CLS_RED:      illegal_d = vstart_bad;
      CLS_WRED:     illegal_d = vstart_bad || !data_w_ok;
      CLS_LOAD:     illegal_d = mask_bad || !data_pair_ok || !seg_ok;
      CLS_STORE:    illegal_d = !data_pair_ok || !seg_ok;
      CLS_IDXLOAD:  illegal_d = mask_bad || !idx_pair_ok || !seg_ok;
      CLS_IDXSTORE: illegal_d = !idx_pair_ok || !seg_ok;
      default:      illegal_d = 1'b1;
    endcase
    illegal_d = illegal_d || vtype_ill;
  end

  // idx_w_ok is only needed inside the index pair check
  logic unused_idx_w;
  assign unused_idx_w = idx_w_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_q <= 1'b0;
      ovl_ok_q  <= 1'b0;
    end else begin
      illegal_q <= illegal_d;
      ovl_ok_q  <= ovl_ok_d;
    end
  end
endmodule

// File: rtl/vec_legal_chk_sva.sv
module vec_legal_chk_sva #(
  parameter int VSTART_W = 16,
  parameter int REG_W    = 5,
  parameter int NF_W     = 4,
  parameter int EEW_W    = 8,
  parameter int POW_W    = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [3:0]              cls_sel,
  input logic                    vtype_ill,
  input logic [VSTART_W-1:0]     vstart,
  input logic [REG_W-1:0]        vd_idx,
  input logic                    vm,
  input logic [NF_W-1:0]         seg_nf,
  input logic [EEW_W-1:0]        data_eew,
  input logic signed [POW_W-1:0] data_pow,
  input logic signed [POW_W-1:0] ovl_src_pow,
  input logic signed [POW_W-1:0] ovl_dst_pow,
  input logic                    illegal_q,
  input logic                    ovl_ok_q
);
  // R1
  vill_forces_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(vtype_ill)) |-> illegal_q);

  // R3
  masked_v0_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cls_sel) == 4'd0 && !$past(vm) && $past(vd_idx) == '0)
      |-> illegal_q);

  // R5
  reduction_vstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(cls_sel) == 4'd3 || $past(cls_sel) == 4'd4) &&
     $past(vstart) != '0) |-> illegal_q);

  // R9
  unknown_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cls_sel) > 4'd8) |-> illegal_q);

  // R7
  plain_store_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cls_sel) == 4'd6 && !$past(vtype_ill) &&
     $past(data_eew) == EEW_W'(8) && $past(data_pow) == '0 &&
     $past(seg_nf) == NF_W'(8)) |-> !illegal_q);

  // R11
  equal_groups_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ovl_src_pow) == $past(ovl_dst_pow)) |-> ovl_ok_q);
endmodule

bind vec_legal_chk vec_legal_chk_sva #(
  .VSTART_W(VSTART_W), .REG_W(REG_W), .NF_W(NF_W), .EEW_W(EEW_W), .POW_W(POW_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cls_sel(cls_sel), .vtype_ill(vtype_ill),
  .vstart(vstart), .vd_idx(vd_idx), .vm(vm), .seg_nf(seg_nf),
  .data_eew(data_eew), .data_pow(data_pow), .ovl_src_pow(ovl_src_pow),
  .ovl_dst_pow(ovl_dst_pow), .illegal_q(illegal_q), .ovl_ok_q(ovl_ok_q)
);

// File: tb/vec_legal_chk_test.sv
`timescale 1ns/1ps
module vec_legal_chk_test;
  localparam int ELEN = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [3:0]        cls_sel;
  logic              vtype_ill;
  logic [15:0]       vstart;
  logic [4:0]        vd_idx;
  logic              vm;
  logic [3:0]        seg_nf;
  logic [7:0]        data_eew;
  logic signed [3:0] data_pow;
  logic [7:0]        idx_eew;
  logic signed [3:0] idx_pow;
  logic [4:0]        ovl_src_idx;
  logic signed [3:0] ovl_src_pow;
  logic signed [3:0] ovl_dst_pow;
  logic              illegal_q;
  logic              ovl_ok_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vec_legal_chk uut (
    .clk(clk), .rst_n(rst_n), .cls_sel(cls_sel), .vtype_ill(vtype_ill),
    .vstart(vstart), .vd_idx(vd_idx), .vm(vm), .seg_nf(seg_nf),
    .data_eew(data_eew), .data_pow(data_pow), .idx_eew(idx_eew), .idx_pow(idx_pow),
    .ovl_src_idx(ovl_src_idx), .ovl_src_pow(ovl_src_pow), .ovl_dst_pow(ovl_dst_pow),
    .illegal_q(illegal_q), .ovl_ok_q(ovl_ok_q));

  function automatic bit m_pair(int e, int p);
    return (e >= 8) && (e <= ELEN) && (p >= -3) && (p <= 3);
  endfunction

  function automatic bit m_seg(int nf, int p);
    if (p < 0) return (nf / (2 ** (-p))) <= 8;
    return (nf * (2 ** p)) <= 8;
  endfunction

  function automatic bit m_illegal();
    bit mb;
    int de, dp, ie, ip, nf;
    de = data_eew; dp = data_pow; ie = idx_eew; ip = idx_pow; nf = seg_nf;
    mb = (vm == 1'b0) && (vd_idx == 0);
    if (vtype_ill) return 1;
    case (cls_sel)
      0: return mb;
      1: return vd_idx == 0;
      2: return mb || !m_pair(de, dp);
      3: return vstart != 0;
      4: return (vstart != 0) || de < 8 || de > ELEN;
      5: return mb || !m_pair(de, dp) || !m_seg(nf, dp);
      6: return !m_pair(de, dp) || !m_seg(nf, dp);
      7: return mb || !m_pair(ie, ip) || !m_seg(nf, dp);
      8: return !m_pair(ie, ip) || !m_seg(nf, dp);
      default: return 1;
    endcase
  endfunction

  function automatic bit m_ovl();
    int s, d, sp, dp, gs, gd;
    s = ovl_src_idx; d = vd_idx; sp = ovl_src_pow; dp = ovl_dst_pow;
    gs = (sp > 0) ? 2 ** sp : 1;
    gd = (dp > 0) ? 2 ** dp : 1;
    if (sp < dp) return (s + gs <= d) || (s >= d + gd) || ((s + gs == d + gd) && sp >= 0);
    if (sp > dp) return (d <= s) || (d >= s + gs);
    return 1;
  endfunction

  task automatic cmp(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic idle();
    cls_sel = 0; vtype_ill = 0; vstart = 0; vd_idx = 5'd4; vm = 1;
    seg_nf = 1; data_eew = 8'd32; data_pow = 0; idx_eew = 8'd16; idx_pow = 0;
    ovl_src_idx = 0; ovl_src_pow = 0; ovl_dst_pow = 0;
  endtask

  // inputs were set just after a falling edge; the verdict is due after the
  // next rising edge and is sampled at the following falling edge
  task automatic step(string tag);
    bit ei, eo;
    ei = m_illegal();
    eo = m_ovl();
    @(negedge clk);
    cmp({tag, " illegal"}, illegal_q, ei);
    cmp({tag, " overlap"}, ovl_ok_q, eo);
  endtask

  task automatic ins(int c, bit ill, int vs, int vd, bit m, int nf,
                     int de, int dp, int ie, int ip, string tag);
    cls_sel = 4'(c); vtype_ill = ill; vstart = 16'(vs); vd_idx = 5'(vd); vm = m;
    seg_nf = 4'(nf); data_eew = 8'(de); data_pow = 4'(dp);
    idx_eew = 8'(ie); idx_pow = 4'(ip);
    step(tag);
  endtask

  task automatic ovl(int s, int sp, int d, int dp, string tag);
    idle();
    ovl_src_idx = 5'(s); ovl_src_pow = 4'(sp); vd_idx = 5'(d); ovl_dst_pow = 4'(dp);
    step(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle();
    vtype_ill = 1;
    repeat (3) @(negedge clk);
    cmp("R12 reset illegal", illegal_q, 1'b0);
    cmp("R12 reset overlap", ovl_ok_q, 1'b0);
    rst_n = 1;
    idle();
    step("R12 first");

    // R1: vill over all classes
    for (int c = 0; c < 16; c++) ins(c, 1, 0, 4, 1, 1, 32, 0, 16, 0, "R1 vill");
    for (int c = 0; c < 9; c++)  ins(c, 0, 0, 4, 1, 1, 32, 0, 16, 0, "R1 clean");
    // R9
    for (int c = 9; c < 16; c++) ins(c, 0, 0, 4, 1, 1, 32, 0, 16, 0, "R9 bad code");
    // R2
    ins(2, 0, 0, 4, 1, 1, 8, -3, 16, 0, "R2 low edge");
    ins(2, 0, 0, 4, 1, 1, 64, 3, 16, 0, "R2 high edge");
    ins(2, 0, 0, 4, 1, 1, 4, 0, 16, 0, "R2 eew small");
    ins(2, 0, 0, 4, 1, 1, 128, 0, 16, 0, "R2 eew big");
    ins(5, 0, 0, 4, 1, 1, 32, -4, 16, 0, "R2 pow low");
    ins(6, 0, 0, 4, 1, 1, 32, 4, 16, 0, "R2 pow high");
    ins(7, 0, 0, 4, 1, 1, 7, 9, 16, 0, "R2 index pair used");
    ins(8, 0, 0, 4, 1, 1, 32, 0, 16, 5, "R2 index pow bad");
    // R3
    ins(0, 0, 0, 0, 0, 1, 32, 0, 16, 0, "R3 normal v0 masked");
    ins(0, 0, 0, 0, 1, 1, 32, 0, 16, 0, "R3 normal v0 unmasked");
    ins(5, 0, 0, 0, 0, 1, 32, 0, 16, 0, "R3 load v0 masked");
    ins(7, 0, 0, 0, 0, 1, 32, 0, 16, 0, "R3 idx load v0 masked");
    // R4
    ins(1, 0, 0, 0, 1, 1, 32, 0, 16, 0, "R4 v0 unmasked");
    ins(1, 0, 0, 1, 0, 1, 32, 0, 16, 0, "R4 v1 masked");
    // R5 / R6
    ins(3, 0, 1, 4, 1, 1, 32, 0, 16, 0, "R5 red vstart");
    ins(4, 0, 9, 4, 1, 1, 32, 0, 16, 0, "R5 wred vstart");
    ins(4, 0, 0, 4, 1, 1, 64, 7, 16, 0, "R6 pow ignored");
    ins(4, 0, 0, 4, 1, 1, 72, 0, 16, 0, "R6 eew too wide");
    // R7
    ins(5, 0, 0, 4, 1, 8, 32, 0, 16, 0, "R7 8x1");
    ins(5, 0, 0, 4, 1, 2, 32, 2, 16, 0, "R7 2x4");
    ins(5, 0, 0, 4, 1, 3, 32, 2, 16, 0, "R7 3x4");
    ins(6, 0, 0, 4, 1, 9, 32, 0, 16, 0, "R7 9x1");
    ins(6, 0, 0, 4, 1, 15, 32, -1, 16, 0, "R7 15 half");
    ins(8, 0, 0, 4, 1, 3, 32, 2, 16, 0, "R7 idx uses data pow");
    ins(7, 0, 0, 4, 1, 2, 32, 2, 16, -3, "R7 idx data pow ok");
    // R8
    ins(6, 0, 0, 0, 0, 1, 32, 0, 16, 0, "R8 store v0 masked");
    ins(8, 0, 0, 0, 0, 1, 32, 0, 16, 0, "R8 idx store v0 masked");
    // R10
    ovl(8, 0, 8, 1, "R10 shares start");
    ovl(9, 0, 8, 1, "R10 same end");
    ovl(9, -1, 8, 1, "R10 same end fractional");
    ovl(10, 0, 8, 1, "R10 disjoint above");
    ovl(7, 0, 8, 1, "R10 disjoint below");
    ovl(31, 0, 24, 3, "R10 end at 31");
    // R11
    ovl(8, 2, 8, 0, "R11 dst at src start");
    ovl(8, 2, 10, 0, "R11 dst inside");
    ovl(8, 2, 12, 0, "R11 dst past end");
    ovl(8, 2, 6, 0, "R11 dst below");
    ovl(28, 2, 31, 1, "R11 dst inside at top");
    ovl(5, 1, 5, 1, "R11 equal");

    // random sweep, compared on every clock
    for (int i = 0; i < 4000; i++) begin
      cls_sel = 4'($urandom_range(0, 10));
      vtype_ill = ($urandom_range(0, 9) == 0);
      vstart = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'd0;
      vd_idx = 5'($urandom); vm = 1'($urandom);
      seg_nf = 4'($urandom);
      data_eew = 8'(8 << $urandom_range(0, 4)) - 8'($urandom_range(0, 1));
      data_pow = 4'($urandom); idx_eew = 8'($urandom_range(0, 80)); idx_pow = 4'($urandom);
      ovl_src_idx = 5'($urandom); ovl_src_pow = 4'($urandom); ovl_dst_pow = 4'($urandom);
      step("R12 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule